// File: doc/BRIEF.md
# I2C Target Write-Data Acknowledge Controller

This block runs the data phase of an I2C target write once the address stage has accepted the transfer. A bit-level shifter feeds it with a strobe for each falling SCL edge and the edge's position in the 9-clock frame (1 to 9), the assembled byte, and stop and repeated-start strobes. The block places each completed byte in a one-entry receive buffer and counts down a software-loaded byte counter. It also decides the SDA level for the acknowledge clock and asks the pin logic to hold SCL low at three points in the frame.

Software reads the buffer through a read strobe or empties it with a clear command. It chooses the acknowledge level while SCL is held and releases a hold by clearing the stretch bit. The acknowledge-time, NACK and stop flags are cleared by write-one strobes. When the byte counter runs out, the acknowledge level comes from a separate end-of-count bit instead of the normal acknowledge-data bit. This lets the transfer end with a NACK without software stepping in. If a byte arrives while the buffer is still full, the byte is dropped and the next acknowledge is forced to NACK. The block then waits for the stop condition.

Top module: `i2c_tgt_rx_ack`

## Requirements
- R1: After reset the block is inactive, `scl_hold` is 0, `sda_ack` is 1 (released), and `rx_full`, `ovf`, `stretch`, `ackt_flag`, `nack_flag`, `stop_flag`, `irq` and `addr_restart` are all 0.
- R2: While receiving, an edge strobe numbered 8 with the buffer empty copies `rx_byte` into `rx_buf` and sets `rx_full` (which is also the receive interrupt). It also decrements `byte_cnt` by one, saturating at 0. Each result is visible one clock after the strobe.
- R3: An edge-8 strobe while `rx_full` is 1 sets `ovf` and leaves `rx_buf` holding the older byte. While `ovf` is 1 the acknowledge level is forced to 1 (NACK). The edge-9 strobe that follows sets `nack_flag`, and the block then waits for a stop.
- R4: Between edge 8 and edge 9, with no overflow, `sda_ack` equals `ack_data` when `byte_cnt` is nonzero and `ack_eoc` when `byte_cnt` is 0 (0 means ACK). At all other times `sda_ack` is 1. `sda_ack` follows a change of `ack_data` made during a hold.
- R5: An edge-7 strobe with `rx_full` still 1 sets `stretch`. Unless `stretch_dis` is 1, `scl_hold` is also raised. After the buffer is read or cleared, `stretch` and `scl_hold` return to 0 within two clocks, with no software clear.
- R6: With `wr_hold_en` 1 and `stretch_dis` 0, the edge-8 strobe sets `stretch` and raises `scl_hold`. A `stretch_clr` pulse drops both.
- R7: The edge-9 strobe sets `ackt_flag`, and `irq` equals `ackt_flag` AND `ack_hold_en`. With `ack_hold_en` 1, an ACK sent and `stretch_dis` 0, `stretch` is set and `scl_hold` stays 1 until both `stretch` and `ackt_flag` are cleared. After a NACK, `stretch` keeps its value.
- R8: A `rd_buf` or `clr_buf` pulse clears `rx_full` one clock later. `clr_buf` also clears `ovf`.
- R9: While the block is active, `stop_det` sets `stop_flag` and makes the block inactive. After a NACK, edge strobes are ignored until the stop arrives.
- R10: While the block is active, `restart_det` makes it inactive and pulses `addr_restart` for one clock, so control passes back to the address stage. `stop_flag` is not set.
- R11: While `stretch_dis` is 1, `scl_hold` stays 0 whatever the hold enables and buffer state are.
- R12: While the block is inactive, edge strobes do not change `rx_full`, `rx_buf` or `byte_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Address accepted for a write; begin the data phase |
| fall | input | 1 | Falling SCL edge strobe from the shifter |
| edge_num | input | EDGE_W | Position of that edge in the frame, 1 to 9 |
| rx_byte | input | DATA_W | Byte assembled by the shifter |
| stop_det | input | 1 | Stop condition seen |
| restart_det | input | 1 | Repeated start seen |
| rd_buf | input | 1 | Software read of the receive buffer |
| clr_buf | input | 1 | Clear-buffer command; also clears overflow |
| cnt_wr | input | 1 | Load `byte_cnt` from `cnt_load` |
| cnt_load | input | CNT_W | Byte count value to load |
| ack_data | input | 1 | Acknowledge level while the count is nonzero |
| ack_eoc | input | 1 | Acknowledge level once the count is zero |
| wr_hold_en | input | 1 | Hold SCL after each byte lands |
| ack_hold_en | input | 1 | Hold SCL and interrupt after the acknowledge clock |
| stretch_dis | input | 1 | Never hold SCL |
| stretch_clr | input | 1 | Software clears the stretch bit |
| ackt_clr | input | 1 | Clear the acknowledge-time flag |
| nack_clr | input | 1 | Clear the NACK flag |
| stop_clr | input | 1 | Clear the stop flag |
| active | output | 1 | Data phase in progress |
| sda_ack | output | 1 | SDA level for the acknowledge clock (1 = released) |
| scl_hold | output | 1 | Request to hold SCL low |
| stretch | output | 1 | Stretch bit |
| rx_buf | output | DATA_W | Receive buffer |
| rx_full | output | 1 | Buffer full and receive interrupt |
| ovf | output | 1 | Receive overflow |
| nack_flag | output | 1 | NACK forced by an error |
| ackt_flag | output | 1 | Acknowledge clock finished |
| stop_flag | output | 1 | Stop seen during the data phase |
| irq | output | 1 | Shared interrupt |
| byte_cnt | output | CNT_W | Remaining byte count |
| addr_restart | output | 1 | One-clock pulse returning control to address matching |

## Verification
Every per-frame decision is registered one clock after its edge strobe, so a wrong internal state shows at the ports on the next clock. A lost buffer-full bit shows as a missing hold at edge 7 or a missing overflow at edge 8. A counter that is off by one shows as `sda_ack` taking the wrong source in the acknowledge window. A wrong state after a NACK shows as a changed `rx_buf` when later edges arrive before the stop. A stuck hold register shows as `scl_hold` staying 1 one or two clocks after the release event, which is why hold releases are checked with that margin.

// File: rtl/i2c_tgt_rx_ack.sv
module i2c_tgt_rx_ack #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int EDGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fall,
  input  logic [EDGE_W-1:0] edge_num,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              stop_det,
  input  logic              restart_det,
  input  logic              rd_buf,
  input  logic              clr_buf,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_load,
  input  logic              ack_data,
  input  logic              ack_eoc,
  input  logic              wr_hold_en,
  input  logic              ack_hold_en,
  input  logic              stretch_dis,
  input  logic              stretch_clr,
  input  logic              ackt_clr,
  input  logic              nack_clr,
  input  logic              stop_clr,
  output logic              active,
  output logic              sda_ack,
  output logic              scl_hold,
  output logic              stretch,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_full,
  output logic              ovf,
  output logic              nack_flag,
  output logic              ackt_flag,
  output logic              stop_flag,
  output logic              irq,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              addr_restart
);

  localparam logic [EDGE_W-1:0] EDGE_SEVEN = EDGE_W'(7);
  localparam logic [EDGE_W-1:0] EDGE_EIGHT = EDGE_W'(8);
  localparam logic [EDGE_W-1:0] EDGE_NINE  = EDGE_W'(9);
  localparam logic [CNT_W-1:0]  CNT_ZERO   = '0;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_ACK, ST_WSTOP} phase_t;

  phase_t phase;
  logic   buf_wait;
  logic   hold_nine;

  logic at7, at8, at9, ack_lvl, bus_end, buf_rd, set9_hold;

  assign at7     = fall && edge_num == EDGE_SEVEN && phase == ST_RECV;
  assign at8     = fall && edge_num == EDGE_EIGHT && phase == ST_RECV;
  assign at9     = fall && edge_num == EDGE_NINE  && phase == ST_ACK;
  assign ack_lvl = ovf ? 1'b1 : (byte_cnt == CNT_ZERO ? ack_eoc : ack_data);
  assign bus_end = (stop_det || restart_det) && phase != ST_IDLE;
  assign buf_rd  = rd_buf || clr_buf;
  assign set9_hold = at9 && ack_hold_en && !ack_lvl && !stretch_dis;

  assign active   = phase != ST_IDLE;
  assign sda_ack  = (phase == ST_ACK) ? ack_lvl : 1'b1;
  assign scl_hold = !stretch_dis && (stretch || hold_nine);
  assign irq      = ackt_flag && ack_hold_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_IDLE;
    end else if (bus_end) begin
      phase <= ST_IDLE;
    end else begin
      case (phase)
        ST_IDLE:  if (start) phase <= ST_RECV;
        ST_RECV:  if (at8) phase <= ST_ACK;
        ST_ACK:   if (at9) phase <= ack_lvl ? ST_WSTOP : ST_RECV;
        default:  phase <= ST_WSTOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (at8 && !rx_full) begin
        rx_buf  <= rx_byte;
        rx_full <= 1'b1;
      end else if (buf_rd) begin
        rx_full <= 1'b0;
      end
      if (at8 && rx_full) ovf <= 1'b1;
      else if (clr_buf)   ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          byte_cnt <= '0;
    else if (cnt_wr)                     byte_cnt <= cnt_load;
    else if (at8 && byte_cnt != CNT_ZERO) byte_cnt <= byte_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stretch   <= 1'b0;
      buf_wait  <= 1'b0;
      hold_nine <= 1'b0;
    end else begin
      if ((at7 && rx_full && !buf_rd) || (at8 && wr_hold_en && !stretch_dis) || set9_hold)
        stretch <= 1'b1;
      else if (stretch_clr || (buf_wait && !rx_full))
        stretch <= 1'b0;

      if (at7 && rx_full && !buf_rd)  buf_wait <= 1'b1;
      else if (!rx_full || bus_end)   buf_wait <= 1'b0;

      if (set9_hold)                                  hold_nine <= 1'b1;
      else if ((!stretch && !ackt_flag) || bus_end)   hold_nine <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackt_flag    <= 1'b0;
      nack_flag    <= 1'b0;
      stop_flag    <= 1'b0;
      addr_restart <= 1'b0;
    end else begin
      if (at9)          ackt_flag <= 1'b1;
      else if (ackt_clr) ackt_flag <= 1'b0;

      if (at9 && ovf)    nack_flag <= 1'b1;
      else if (nack_clr) nack_flag <= 1'b0;

      if (stop_det && !restart_det && phase != ST_IDLE) stop_flag <= 1'b1;
      else if (stop_clr)                                stop_flag <= 1'b0;

      addr_restart <= restart_det && phase != ST_IDLE;
    end
  end

endmodule

// File: rtl/i2c_tgt_rx_ack_chk.sv
module i2c_tgt_rx_ack_chk #(
  parameter int DATA_W = 8,
  parameter int EDGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fall,
  input logic [EDGE_W-1:0] edge_num,
  input logic              rd_buf,
  input logic              clr_buf,
  input logic              active,
  input logic [DATA_W-1:0] rx_buf,
  input logic              rx_full,
  input logic              ovf,
  input logic              ackt_flag,
  input logic              stop_flag,
  input logic              addr_restart
);

  assert_fill_on_eighth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(fall) && $past(edge_num) == EDGE_W'(8));

  assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $stable(rx_buf));

  assert_ackt_on_ninth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ackt_flag) |-> $past(fall) && $past(edge_num) == EDGE_W'(9));

  assert_read_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf || clr_buf) && !(fall && edge_num == EDGE_W'(8)) |=> !rx_full);

  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> !active);

  assert_restart_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_restart |-> !active);

endmodule

bind i2c_tgt_rx_ack i2c_tgt_rx_ack_chk #(.DATA_W(DATA_W), .EDGE_W(EDGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fall(fall), .edge_num(edge_num),
  .rd_buf(rd_buf), .clr_buf(clr_buf), .active(active), .rx_buf(rx_buf),
  .rx_full(rx_full), .ovf(ovf), .ackt_flag(ackt_flag), .stop_flag(stop_flag),
  .addr_restart(addr_restart)
);

// File: tb/i2c_tgt_rx_ack_tb.sv
module i2c_tgt_rx_ack_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic start = 0, fall = 0, stop_det = 0, restart_det = 0, rd_buf = 0, clr_buf = 0;
  logic [3:0] edge_num = 0;
  logic [7:0] rx_byte = 0, cnt_load = 0;
  logic cnt_wr = 0, ack_data = 0, ack_eoc = 1, wr_hold_en = 0, ack_hold_en = 0;
  logic stretch_dis = 0, stretch_clr = 0, ackt_clr = 0, nack_clr = 0, stop_clr = 0;
  logic active, sda_ack, scl_hold, stretch, rx_full, ovf, nack_flag, ackt_flag, stop_flag, irq, addr_restart;
  logic [7:0] rx_buf, byte_cnt;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tgt_rx_ack u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fall(fall), .edge_num(edge_num),
    .rx_byte(rx_byte), .stop_det(stop_det), .restart_det(restart_det),
    .rd_buf(rd_buf), .clr_buf(clr_buf), .cnt_wr(cnt_wr), .cnt_load(cnt_load),
    .ack_data(ack_data), .ack_eoc(ack_eoc), .wr_hold_en(wr_hold_en),
    .ack_hold_en(ack_hold_en), .stretch_dis(stretch_dis), .stretch_clr(stretch_clr),
    .ackt_clr(ackt_clr), .nack_clr(nack_clr), .stop_clr(stop_clr),
    .active(active), .sda_ack(sda_ack), .scl_hold(scl_hold), .stretch(stretch),
    .rx_buf(rx_buf), .rx_full(rx_full), .ovf(ovf), .nack_flag(nack_flag),
    .ackt_flag(ackt_flag), .stop_flag(stop_flag), .irq(irq), .byte_cnt(byte_cnt),
    .addr_restart(addr_restart)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    {start, fall, stop_det, restart_det, rd_buf, clr_buf, cnt_wr} = '0;
    {wr_hold_en, ack_hold_en, stretch_dis, stretch_clr, ackt_clr, nack_clr, stop_clr} = '0;
    ack_data = 0; ack_eoc = 1;
    tick(); rst_n = 1; tick();
  endtask

  task automatic pulse_edge(input int n, input logic [7:0] b);
    fall = 1; edge_num = 4'(n); rx_byte = b;
    tick();
    fall = 0;
  endtask

  task automatic begin_xfer(input logic [7:0] cnt);
    cnt_load = cnt; cnt_wr = 1; tick(); cnt_wr = 0;
    start = 1; tick(); start = 0;
  endtask

  task automatic edges_upto(input int last, input logic [7:0] b);
    for (int i = 1; i <= last; i++) pulse_edge(i, b);
  endtask

  task automatic pulse_rd();
    rd_buf = 1; tick(); rd_buf = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 active", active, 0);
    check("R1 scl_hold", scl_hold, 0);
    check("R1 sda_ack", sda_ack, 1);
    check("R1 rx_full", rx_full, 0);
    check("R1 flags", {ovf, stretch, ackt_flag, nack_flag, stop_flag, irq, addr_restart}, 0);
  endtask

  task automatic t_basic();
    do_reset();
    begin_xfer(8'd3);
    edges_upto(7, 8'h00);
    check("R5 no hold when empty", scl_hold, 0);
    pulse_edge(8, 8'hA5);
    check("R2 rx_buf", rx_buf, 8'hA5);
    check("R2 rx_full", rx_full, 1);
    check("R2 byte_cnt", byte_cnt, 2);
    check("R4 ack from ack_data", sda_ack, 0);
    pulse_edge(9, 8'h00);
    check("R7 ackt_flag", ackt_flag, 1);
    check("R7 irq off without enable", irq, 0);
    check("R4 released after ack clock", sda_ack, 1);
    check("R7 still active after ACK", active, 1);
    pulse_rd();
    check("R8 read clears full", rx_full, 0);
  endtask

  task automatic t_eoc();
    do_reset();
    ack_hold_en = 1;
    begin_xfer(8'd1);
    edges_upto(8, 8'h3C);
    check("R2 count reaches zero", byte_cnt, 0);
    check("R4 end-of-count level", sda_ack, 1);
    pulse_edge(9, 8'h00);
    check("R7 no stretch after NACK", stretch, 0);
    check("R7 irq", irq, 1);
    pulse_rd();
    edges_upto(8, 8'h77);
    check("R9 edges ignored after NACK", rx_full, 0);
    check("R9 buffer kept", rx_buf, 8'h3C);
    stop_det = 1; tick(); stop_det = 0;
    check("R9 stop flag", stop_flag, 1);
    check("R9 inactive", active, 0);
  endtask

  task automatic t_full7();
    do_reset();
    begin_xfer(8'd5);
    edges_upto(8, 8'h11);
    pulse_edge(9, 8'h00);
    edges_upto(7, 8'h22);
    check("R5 stretch at edge 7", stretch, 1);
    check("R5 hold at edge 7", scl_hold, 1);
    pulse_rd();
    tick();
    check("R5 auto release stretch", stretch, 0);
    check("R5 auto release hold", scl_hold, 0);
  endtask

  task automatic t_wrhold();
    do_reset();
    wr_hold_en = 1;
    begin_xfer(8'd4);
    edges_upto(8, 8'h5A);
    check("R6 stretch at edge 8", stretch, 1);
    check("R6 hold at edge 8", scl_hold, 1);
    ack_data = 1; #1;
    check("R4 follows ack_data change", sda_ack, 1);
    stretch_clr = 1; tick(); stretch_clr = 0;
    check("R6 release by software", scl_hold, 0);
  endtask

  task automatic t_ackhold();
    do_reset();
    ack_hold_en = 1;
    begin_xfer(8'd4);
    edges_upto(8, 8'h66);
    pulse_edge(9, 8'h00);
    check("R7 stretch on ACK", stretch, 1);
    check("R7 hold on ACK", scl_hold, 1);
    check("R7 irq", irq, 1);
    stretch_clr = 1; tick(); stretch_clr = 0;
    tick();
    check("R7 hold kept while ackt set", scl_hold, 1);
    ackt_clr = 1; tick(); ackt_clr = 0;
    tick();
    check("R7 hold released", scl_hold, 0);
  endtask

  task automatic t_ovf();
    do_reset();
    stretch_dis = 1; wr_hold_en = 1; ack_hold_en = 1;
    begin_xfer(8'd4);
    edges_upto(8, 8'h11);
    check("R11 no hold on write-hold", scl_hold, 0);
    pulse_edge(9, 8'h00);
    edges_upto(7, 8'h22);
    check("R5 stretch bit set when disabled", stretch, 1);
    check("R11 no hold at edge 7", scl_hold, 0);
    pulse_edge(8, 8'h22);
    check("R3 ovf", ovf, 1);
    check("R3 old byte kept", rx_buf, 8'h11);
    check("R3 forced NACK", sda_ack, 1);
    pulse_edge(9, 8'h00);
    check("R3 nack_flag", nack_flag, 1);
    check("R3 waits for stop", active, 1);
    stop_det = 1; tick(); stop_det = 0;
    check("R9 idle after stop", active, 0);
    clr_buf = 1; tick(); clr_buf = 0;
    check("R8 clr_buf full", rx_full, 0);
    check("R8 clr_buf ovf", ovf, 0);
  endtask

  task automatic t_restart();
    do_reset();
    begin_xfer(8'd4);
    edges_upto(8, 8'h44);
    pulse_edge(9, 8'h00);
    restart_det = 1; tick(); restart_det = 0;
    check("R10 addr_restart pulse", addr_restart, 1);
    check("R10 inactive", active, 0);
    check("R10 no stop flag", stop_flag, 0);
    tick();
    check("R10 pulse one clock", addr_restart, 0);
  endtask

  task automatic t_idle();
    do_reset();
    cnt_load = 8'd6; cnt_wr = 1; tick(); cnt_wr = 0;
    edges_upto(8, 8'h99);
    check("R12 full unchanged", rx_full, 0);
    check("R12 buffer unchanged", rx_buf, 0);
    check("R12 count unchanged", byte_cnt, 6);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_eoc();
    t_full7();
    t_wrhold();
    t_ackhold();
    t_ovf();
    t_restart();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule